// File: doc/BRIEF.md
# Multi-channel output compare timer

The block runs a 16-bit free-running counter and five 16-bit compare channels. On every clock each channel checks its compare value against the counter. A match sets that channel's flag, can raise an interrupt if the channel is enabled, and drives a pin action. Software programs the edges of a pulse by loading a compare value and changing it after each match. Because the pin changes at a known count, the pulse width is exact to one counter tick, whatever the software latency.

Channels 2 to 5 each own one output pin. A two-bit field per channel picks the action on that pin. Channel 1 owns no pin of its own. Instead, on its match it drives any subset of the five pins to preset levels, using a mask register and a data register. All state is reached through a byte-wide register port. Reads are combinational and writes happen on the clock edge. A compare register that is not used for compare works as plain storage. Writing the high byte of a compare register holds that channel off for one cycle. This keeps a half-updated value from firing.

Top module: `oc_timer`

## Requirements
- R1: After reset all compare registers read 0xFFFF. The counter, the pins, the flags, the interrupt enables, the mode byte, the mask and the data all read zero, and irq_o is low.
- R2: The counter increments once per clock and wraps from 0xFFFF to 0x0000. Address 0x0A reads its high byte and address 0x0B reads its low byte.
- R3: When a channel's compare value equals the counter and the channel is not held off, bit (channel-1) of the flag register at address 0x0F is set at that clock edge. Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. A match in the same cycle as a clear leaves the flag set.
- R4: irq_o is high exactly when some flag bit is set and the same bit of the enable register at address 0x10 is 1.
- R5: Channel k (2 to 5) drives pins_o[k-1] on its match at the same edge as the flag. The action comes from bits [2(k-2)+1:2(k-2)] of the mode register at address 0x0C: 00 keeps the pin, 01 toggles it, 10 drives it low, 11 drives it high. With no match the pins hold.
- R6: The pin action is taken on every match, even while the channel's flag is still set from an earlier match.
- R7: On a channel 1 match, every pin whose bit is 1 in the mask register (0x0D) takes the matching bit of the data register (0x0E). This overrides the action of any other channel that matches on the same pin in the same cycle.
- R8: The mask and data registers keep only bits [4:0]. Bits [7:5] read as zero.
- R9: A write to a compare register's high byte blocks that channel's match in the next cycle. A write to the low byte does not block.
- R10: Channel k's compare register sits at addresses 2(k-1) (high byte) and 2(k-1)+1 (low byte). Each byte can be written and read back on its own, so the register also works as storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock; the counter ticks once per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register byte address |
| wr_en_i | input | 1 | Write strobe for wdata_i at addr_i |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data at addr_i |
| pins_o | output | 5 | Compare output pins, bit k-1 for channel k |
| irq_o | output | 1 | Interrupt request |

## Verification
Two things can fall on the same clock edge. The first is a channel 1 match together with another channel's match that drives the same pin. The bench provokes this by loading both compare registers with the same future count, after first driving the pin high. It then checks that the pin ends at the channel 1 data level. The second is a flag clear written in the very cycle a match sets that flag. The random phase provokes this by mixing flag writes with compare values placed a few counts ahead. A bench model tracks flags, pins, irq and every readable byte cycle by cycle and judges the outcome.

// File: rtl/oc_timer_pkg.sv
package oc_timer_pkg;
  localparam int CNT_W    = 16;
  localparam int NUM_CH   = 5;
  localparam int ADDR_W   = 5;
  localparam int BYTE_W   = 8;
  localparam int CMP_BYTES = 2 * NUM_CH;

  localparam int A_CNT_HI = CMP_BYTES;
  localparam int A_CNT_LO = CMP_BYTES + 1;
  localparam int A_MODE   = CMP_BYTES + 2;
  localparam int A_MASK   = CMP_BYTES + 3;
  localparam int A_DATA   = CMP_BYTES + 4;
  localparam int A_FLAG   = CMP_BYTES + 5;
  localparam int A_IEN    = CMP_BYTES + 6;

  typedef enum logic [1:0] {
    PIN_KEEP   = 2'b00,
    PIN_TOGGLE = 2'b01,
    PIN_LOW    = 2'b10,
    PIN_HIGH   = 2'b11
  } pin_act_e;
endpackage

// File: rtl/oc_free_counter.sv
module oc_free_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/oc_cmp_chan.sv
module oc_cmp_chan #(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_hi_i,
  input  logic          wr_lo_i,
  input  logic [BW-1:0] wdata_i,
  input  logic [W-1:0]  cnt_i,
  output logic [W-1:0]  val_o,
  output logic          match_o
);
  logic [W-1:0] val_q;
  logic         hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '1;
      hold_q <= 1'b0;
    end else begin
      if (wr_hi_i) val_q[W-1:W-BW] <= wdata_i;
      if (wr_lo_i) val_q[BW-1:0]   <= wdata_i;
      hold_q <= wr_hi_i;
    end
  end

  assign val_o   = val_q;
  assign match_o = (val_q == cnt_i) && !hold_q;

  // R9: a high-byte write holds the channel off for the following cycle
  a_r9_hi_write_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> !match_o);
endmodule

// File: rtl/oc_pin_ctrl.sv
module oc_pin_ctrl
  import oc_timer_pkg::*;
#(
  parameter int N = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     match_i,
  input  logic [2*N-3:0]   mode_i,
  input  logic [N-1:0]     mask_i,
  input  logic [N-1:0]     data_i,
  output logic [N-1:0]     pins_o
);
  logic [N-1:0] pins_q, pins_d;

  always_comb begin
    pins_d = pins_q;
    for (int k = 1; k < N; k++) begin
      if (match_i[k]) begin
        unique case (pin_act_e'(mode_i[2*(k-1) +: 2]))
          PIN_KEEP:   pins_d[k] = pins_q[k];
          PIN_TOGGLE: pins_d[k] = ~pins_q[k];
          PIN_LOW:    pins_d[k] = 1'b0;
          PIN_HIGH:   pins_d[k] = 1'b1;
          default:    pins_d[k] = pins_q[k];
        endcase
      end
    end
    // master channel applied last so it wins on shared pins
    if (match_i[0]) pins_d = (pins_d & ~mask_i) | (data_i & mask_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pins_q <= '0;
    else         pins_q <= pins_d;
  end

  assign pins_o = pins_q;

  a_r7_master_forces_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i[0] |=> ((pins_o & $past(mask_i)) == ($past(data_i) & $past(mask_i))));

  a_r5_pins_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i == '0) |=> $stable(pins_o));
endmodule

// File: rtl/oc_timer.sv
module oc_timer
  import oc_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] pins_o,
  output logic              irq_o
);
  localparam int MODE_W = 2 * (NUM_CH - 1);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cmp_val [NUM_CH];
  logic [NUM_CH-1:0] match;
  logic [NUM_CH-1:0] wr_hi, wr_lo;
  logic [MODE_W-1:0] mode_q;
  logic [NUM_CH-1:0] mask_q, data_q, flags_q, ien_q;
  logic              flag_wr;

  oc_free_counter #(.W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign wr_hi[k] = wr_en_i && (addr_i == ADDR_W'(2 * k));
    assign wr_lo[k] = wr_en_i && (addr_i == ADDR_W'(2 * k + 1));

    oc_cmp_chan #(.W(CNT_W), .BW(BYTE_W)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_hi_i(wr_hi[k]),
      .wr_lo_i(wr_lo[k]),
      .wdata_i(wdata_i),
      .cnt_i  (cnt),
      .val_o  (cmp_val[k]),
      .match_o(match[k])
    );

    a_r3_match_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match[k] |=> flags_q[k]);

    a_r3_flag_clear_needs_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flags_q[k]) |-> $past(flag_wr && wdata_i[k]));
  end

  oc_pin_ctrl #(.N(NUM_CH)) u_pins (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .match_i(match),
    .mode_i (mode_q),
    .mask_i (mask_q),
    .data_i (data_q),
    .pins_o (pins_o)
  );

  assign flag_wr = wr_en_i && (addr_i == ADDR_W'(A_FLAG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      mask_q  <= '0;
      data_q  <= '0;
      ien_q   <= '0;
      flags_q <= '0;
    end else begin
      if (wr_en_i && addr_i == ADDR_W'(A_MODE)) mode_q <= wdata_i[MODE_W-1:0];
      if (wr_en_i && addr_i == ADDR_W'(A_MASK)) mask_q <= wdata_i[NUM_CH-1:0];
      if (wr_en_i && addr_i == ADDR_W'(A_DATA)) data_q <= wdata_i[NUM_CH-1:0];
      if (wr_en_i && addr_i == ADDR_W'(A_IEN))  ien_q  <= wdata_i[NUM_CH-1:0];
      // set dominates a same-cycle clear
      flags_q <= (flags_q & ~(flag_wr ? wdata_i[NUM_CH-1:0] : '0)) | match;
    end
  end

  assign irq_o = |(flags_q & ien_q);

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (addr_i == ADDR_W'(2 * k))     rdata_o = cmp_val[k][CNT_W-1:CNT_W-BYTE_W];
      if (addr_i == ADDR_W'(2 * k + 1)) rdata_o = cmp_val[k][BYTE_W-1:0];
    end
    unique case (int'(addr_i))
      A_CNT_HI: rdata_o = cnt[CNT_W-1:CNT_W-BYTE_W];
      A_CNT_LO: rdata_o = cnt[BYTE_W-1:0];
      A_MODE:   rdata_o = BYTE_W'(mode_q);
      A_MASK:   rdata_o = BYTE_W'(mask_q);
      A_DATA:   rdata_o = BYTE_W'(data_q);
      A_FLAG:   rdata_o = BYTE_W'(flags_q);
      A_IEN:    rdata_o = BYTE_W'(ien_q);
      default:  ;
    endcase
  end

  a_r2_counter_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '1) |=> (cnt == '0));

  a_r4_irq_follows_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match & ien_q & ~(flag_wr ? wdata_i[NUM_CH-1:0] : '0)) != '0 |=> irq_o || !$stable(ien_q));
endmodule

// File: tb/oc_timer_tb.sv
module oc_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_OPS   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [4:0] pins;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  oc_timer dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .addr_i (addr),
    .wr_en_i(wr_en),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .pins_o (pins),
    .irq_o  (irq)
  );

  // bench model
  logic [15:0] m_cnt;
  logic [15:0] m_cmp [5];
  logic [4:0]  m_inh, m_mask, m_data, m_flags, m_ien, m_pins, mm, mp, mf, mi;
  logic [7:0]  m_mode;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_inh = '0; m_mask = '0; m_data = '0;
      m_flags = '0; m_ien = '0; m_pins = '0; m_mode = '0;
      for (int k = 0; k < 5; k++) m_cmp[k] = 16'hFFFF;
    end else begin
      for (int k = 0; k < 5; k++) mm[k] = (m_cmp[k] == m_cnt) && !m_inh[k];
      mp = m_pins;
      for (int k = 1; k < 5; k++)
        if (mm[k])
          case (m_mode[2*(k-1) +: 2])
            2'b01: mp[k] = ~mp[k];
            2'b10: mp[k] = 1'b0;
            2'b11: mp[k] = 1'b1;
            default: ;
          endcase
      if (mm[0]) mp = (mp & ~m_mask) | (m_data & m_mask);
      mf = m_flags;
      if (wr_en && addr == 5'd15) mf = mf & ~wdata[4:0];
      mf = mf | mm;
      mi = '0;
      if (wr_en) begin
        if (addr < 5'd10) begin
          if (!addr[0]) begin m_cmp[addr >> 1][15:8] = wdata; mi[addr >> 1] = 1'b1; end
          else m_cmp[addr >> 1][7:0] = wdata;
        end
        case (addr)
          5'd12: m_mode = wdata;
          5'd13: m_mask = wdata[4:0];
          5'd14: m_data = wdata[4:0];
          5'd16: m_ien  = wdata[4:0];
          default: ;
        endcase
      end
      m_pins = mp; m_flags = mf; m_inh = mi; m_cnt = m_cnt + 16'd1;
    end
  end

  function automatic logic [7:0] m_read(input logic [4:0] a);
    if (a < 5'd10) return a[0] ? m_cmp[a >> 1][7:0] : m_cmp[a >> 1][15:8];
    case (a)
      5'd10: return m_cnt[15:8];
      5'd11: return m_cnt[7:0];
      5'd12: return m_mode;
      5'd13: return {3'b0, m_mask};
      5'd14: return {3'b0, m_data};
      5'd15: return {3'b0, m_flags};
      5'd16: return {3'b0, m_ien};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // wait one cycle, compare ports to the model, release the write strobe
  task automatic step();
    @(negedge clk);
    check("R5 pins", 16'(pins), 16'(m_pins));
    check("R4 irq", 16'(irq), 16'(|(m_flags & m_ien)));
    check("R10 rdata", 16'(rdata), 16'(m_read(addr)));
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    step();
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
    addr = a; wr_en = 1'b0;
    #1;
    check(tag, 16'(rdata), 16'(exp));
  endtask

  task automatic set_cmp(input int ch, input logic [15:0] v);
    wr(5'(2 * (ch - 1)), v[15:8]);
    wr(5'(2 * (ch - 1) + 1), v[7:0]);
  endtask

  initial begin
    logic [15:0] v;
    logic [15:0] c;
    int unsigned seed_init;
    seed_init = $urandom(32'h0C5E_ED01);
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(5'd0, 8'hFF, "R1 cmp1 hi");
    rd(5'd9, 8'hFF, "R1 cmp5 lo");
    rd(5'd13, 8'h00, "R1 mask");
    rd(5'd15, 8'h00, "R1 flags");
    rd(5'd10, 8'h00, "R1 counter");
    check("R1 pins", 16'(pins), 16'h0);
    check("R1 irq", 16'(irq), 16'h0);
    rst_n = 1'b1;
    step();

    // R2 counter step
    rd(5'd11, m_cnt[7:0], "R2 counter lo");
    c = m_cnt;
    step();
    rd(5'd11, c[7:0] + 8'd1, "R2 counter next");

    // R5 toggle, R3 flag, R4 irq
    wr(5'd12, 8'h01);
    wr(5'd16, 8'h02);
    set_cmp(2, m_cnt + 16'd20);
    repeat (25) step();
    check("R5 toggle", 16'(pins[1]), 16'h1);
    rd(5'd15, 8'h02, "R3 flag set");
    check("R4 irq enabled flag", 16'(irq), 16'h1);
    // R6 second match with flag still set
    set_cmp(2, m_cnt + 16'd10);
    repeat (15) step();
    check("R6 toggle again", 16'(pins[1]), 16'h0);
    // R3 write-one-to-clear
    wr(5'd15, 8'h00);
    rd(5'd15, 8'h02, "R3 write zero keeps");
    wr(5'd15, 8'h02);
    rd(5'd15, 8'h00, "R3 write one clears");
    check("R4 irq low", 16'(irq), 16'h0);

    // R7 master channel priority
    wr(5'd12, 8'h0C);
    set_cmp(3, m_cnt + 16'd10);
    repeat (15) step();
    check("R5 drive high", 16'(pins[2]), 16'h1);
    wr(5'd13, 8'h05);
    wr(5'd14, 8'h01);
    v = m_cnt + 16'd20;
    set_cmp(1, v);
    set_cmp(3, v);
    repeat (25) step();
    check("R7 forced high", 16'(pins[0]), 16'h1);
    check("R7 priority low", 16'(pins[2]), 16'h0);

    // R8 implemented bits
    wr(5'd13, 8'hFF);
    rd(5'd13, 8'h1F, "R8 mask width");
    wr(5'd14, 8'hFF);
    rd(5'd14, 8'h1F, "R8 data width");
    wr(5'd13, 8'h00);

    // R9 high-byte write holds the channel off
    wr(5'd12, 8'h30);
    wr(5'd15, 8'h1F);
    v = m_cnt + 16'd3;
    wr(5'd7, v[7:0]);
    wr(5'd6, v[15:8]);
    wr(5'd6, v[15:8]);
    repeat (4) step();
    rd(5'd15, 8'h00, "R9 held flag");
    check("R9 held pin", 16'(pins[3]), 16'h0);
    v = m_cnt + 16'd2;
    wr(5'd6, v[15:8]);
    wr(5'd7, v[7:0]);
    repeat (3) step();
    check("R9 low byte no hold", 16'(pins[3]), 16'h1);

    // R10 storage
    wr(5'd8, 8'hA5);
    wr(5'd9, 8'h5A);
    rd(5'd8, 8'hA5, "R10 hi even");
    rd(5'd9, 8'h5A, "R10 lo odd");

    // random phase
    for (int i = 0; i < RAND_OPS; i++) begin
      int unsigned r;
      int unsigned ch;
      r = $urandom % 8;
      ch = $urandom % 5;
      v = m_cnt + 16'(1 + $urandom % 12);
      case (r)
        0: set_cmp(int'(ch) + 1, v);
        1: wr(5'(2 * ch + 1), v[7:0]);
        2: wr(5'(2 * ch), v[15:8]);
        3: wr(5'd12, 8'($urandom));
        4: wr(($urandom % 2) ? 5'd13 : 5'd14, 8'($urandom));
        5: wr(5'd15, 8'($urandom));
        6: wr(5'd16, 8'($urandom));
        default: begin addr = 5'($urandom % 17); step(); end
      endcase
    end

    // R2 wrap
    while (m_cnt != 16'hFFFF) step();
    rd(5'd10, 8'hFF, "R2 top hi");
    rd(5'd11, 8'hFF, "R2 top lo");
    step();
    rd(5'd10, 8'h00, "R2 wrap hi");
    rd(5'd11, 8'h00, "R2 wrap lo");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule